// File: doc/BRIEF.md
# Byte Rotate and Shift Unit

This unit takes an 8-bit operand together with the current processor condition byte and produces the rotated or shifted value and a revised condition byte. It offers eight operations: two circular rotates, two rotates through the carry bit, two left shifts that differ in the bit entering at the bottom, and an arithmetic and a logical right shift. It also serves the short accumulator encodings of those operations.

A one-bit form select chooses how the condition byte is updated. The full form recomputes sign, zero and parity from the result. The short form touches only carry, half-carry and subtract. Nothing happens until the caller raises a start strobe for one cycle. On the next rising clock edge the result and the new condition byte are captured. Both outputs then stay unchanged until the next strobe.

The surrounding datapath supplies the operand and the condition byte and consumes the registered outputs. Register file access, memory operands and opcode decoding belong to other blocks.

Top module: `byte_rotshift_unit`

## Requirements
- R1: Select codes 0 (rotate left) and 1 (rotate right) are circular. Code 0 copies operand bit 7 into result bit 0 and into carry. Code 1 copies operand bit 0 into result bit 7 and into carry.
- R2: Select codes 2 (left) and 3 (right) rotate through carry. The incoming carry (condition bit 0) fills the vacated bit, and the bit pushed out becomes the new carry.
- R3: Select codes 4 and 5 shift left. Code 4 fills bit 0 with 0 and code 5 fills it with 1. In both, operand bit 7 becomes the carry.
- R4: Select code 6 shifts right and keeps bit 7. Select code 7 shifts right and fills bit 7 with 0. In both, operand bit 0 becomes the carry.
- R5: With form select 0 (full form), the new condition byte is rebuilt as follows:
  - sign (0x80) copies result bit 7;
  - zero (0x40) is set when the result is zero;
  - parity (0x04) is set when the result has an even count of ones;
  - half-carry (0x10) and subtract (0x02) are cleared;
  - carry (0x01) takes the bit shifted out.
- R6: With form select 1 (accumulator form), half-carry and subtract are cleared and carry takes the bit shifted out. Sign, zero and parity keep their incoming values, even when the result is zero.
- R7: Condition bits 0x20 and 0x08 are copied from the incoming condition byte in every operation and in both forms.
- R8: The result and condition outputs change only on the clock edge after a cycle with start high. Changing the inputs while start is low has no effect on the outputs.
- R9: Active-low reset clears the result and condition outputs to zero, whether it arrives before any strobe or after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that captures a new result |
| op_sel | input | 3 | Operation code, 0 to 7 as in R1 to R4 |
| acc_form | input | 1 | 1 selects the accumulator form of the flag update |
| operand | input | DATA_W | Value to rotate or shift |
| flags_in | input | 8 | Current condition byte |
| result | output | DATA_W | Registered rotate or shift result |
| flags_out | output | 8 | Registered new condition byte |

## Verification
The bench aims at the cases where a plausible mistake still yields a believable byte:
- A through-carry rotate with carry clear and set. A design that rotated circularly would return the wrong bottom or top bit.
- An accumulator-form rotate that produces zero. A design that rebuilt all flags would raise the zero flag.
- Results with odd and even counts of ones. An inverted parity sense would show at once.
- An arithmetic right shift of a negative value. Losing the sign bit turns 0xC0 into 0x40.
- The two unused condition bits set on entry. A design that drops them returns them clear.
- Input changes while start is low, and a reset issued mid-run. These expose outputs that follow the inputs or that survive reset.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

   localparam int FLAG_W = 8;
   localparam int OP_W   = 3;

   // condition byte bit positions
   localparam int FB_SIGN   = 7;
   localparam int FB_ZERO   = 6;
   localparam int FB_SPARE5 = 5;
   localparam int FB_HALF   = 4;
   localparam int FB_SPARE3 = 3;
   localparam int FB_PARITY = 2;
   localparam int FB_SUB    = 1;
   localparam int FB_CARRY  = 0;

   localparam logic [FLAG_W-1:0] MASK_SPARE = (8'd1 << FB_SPARE5) | (8'd1 << FB_SPARE3);
   localparam logic [FLAG_W-1:0] MASK_ACC_KEEP =
      ~((8'd1 << FB_HALF) | (8'd1 << FB_SUB) | (8'd1 << FB_CARRY));

   typedef enum logic [OP_W-1:0] {
      OP_ROL_CIRC  = 3'd0,
      OP_ROR_CIRC  = 3'd1,
      OP_ROL_THRU  = 3'd2,
      OP_ROR_THRU  = 3'd3,
      OP_SHL_ZERO  = 3'd4,
      OP_SHL_ONE   = 3'd5,
      OP_SHR_SIGN  = 3'd6,
      OP_SHR_ZERO  = 3'd7
   } rsu_op_e;

endpackage

// File: rtl/rsu_shift_core.sv
module rsu_shift_core
   import rsu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] din,
   input  logic [OP_W-1:0]   op,
   input  logic              carry_in,
   output logic [DATA_W-1:0] dout,
   output logic              carry_out
);

   localparam int BODY_W = DATA_W - 1;

   logic [BODY_W-1:0] left_body;
   logic [BODY_W-1:0] right_body;
   logic              go_left;
   logic              fill_bit;
   rsu_op_e           op_e;

   assign op_e = rsu_op_e'(op);

   // bodies of the shifted word, one wire per bit position
   for (genvar i = 0; i < BODY_W; i++) begin : g_body
      assign left_body[i]  = din[i];
      assign right_body[i] = din[i+1];
   end

   always_comb begin
      go_left  = 1'b0;
      fill_bit = 1'b0;
      unique case (op_e)
         OP_ROL_CIRC: begin go_left = 1'b1; fill_bit = din[DATA_W-1]; end
         OP_ROR_CIRC: begin go_left = 1'b0; fill_bit = din[0];        end
         OP_ROL_THRU: begin go_left = 1'b1; fill_bit = carry_in;      end
         OP_ROR_THRU: begin go_left = 1'b0; fill_bit = carry_in;      end
         OP_SHL_ZERO: begin go_left = 1'b1; fill_bit = 1'b0;          end
         OP_SHL_ONE:  begin go_left = 1'b1; fill_bit = 1'b1;          end
         OP_SHR_SIGN: begin go_left = 1'b0; fill_bit = din[DATA_W-1]; end
         OP_SHR_ZERO: begin go_left = 1'b0; fill_bit = 1'b0;          end
         default:     begin go_left = 1'b0; fill_bit = 1'b0;          end
      endcase
   end

   assign dout      = go_left ? {left_body, fill_bit} : {fill_bit, right_body};
   assign carry_out = go_left ? din[DATA_W-1] : din[0];

endmodule

// File: rtl/rsu_flag_merge.sv
module rsu_flag_merge
   import rsu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              carry,
   input  logic              acc_form,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_new
);

   logic [FLAG_W-1:0] full_flags;
   logic [FLAG_W-1:0] acc_flags;

   always_comb begin
      full_flags            = flags_in & MASK_SPARE;
      full_flags[FB_SIGN]   = res[DATA_W-1];
      full_flags[FB_ZERO]   = (res == '0);
      full_flags[FB_PARITY] = ~(^res);
      full_flags[FB_CARRY]  = carry;
   end

   always_comb begin
      acc_flags           = flags_in & MASK_ACC_KEEP;
      acc_flags[FB_CARRY] = carry;
   end

   assign flags_new = acc_form ? acc_flags : full_flags;

endmodule

// File: rtl/byte_rotshift_unit.sv
module byte_rotshift_unit
   import rsu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic              acc_form,
   input  logic [DATA_W-1:0] operand,
   input  logic [7:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [7:0]        flags_out
);

   if (DATA_W < 2) begin : g_bad_width
      $error("byte_rotshift_unit: DATA_W must be at least 2");
   end
   if (FLAG_W != 8) begin : g_bad_flag_w
      $error("byte_rotshift_unit: condition byte must be 8 bits");
   end

   logic [DATA_W-1:0] res_d;
   logic              carry_d;
   logic [FLAG_W-1:0] flags_d;

   rsu_shift_core #(.DATA_W(DATA_W)) u_core (
      .din       (operand),
      .op        (op_sel),
      .carry_in  (flags_in[FB_CARRY]),
      .dout      (res_d),
      .carry_out (carry_d)
   );

   rsu_flag_merge #(.DATA_W(DATA_W)) u_flags (
      .res       (res_d),
      .carry     (carry_d),
      .acc_form  (acc_form),
      .flags_in  (flags_in),
      .flags_new (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         flags_out <= '0;
      end else if (start) begin
         result    <= res_d;
         flags_out <= flags_d;
      end
   end

endmodule

// File: rtl/byte_rotshift_unit_chk.sv
module byte_rotshift_unit_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        op_sel,
   input logic              acc_form,
   input logic [DATA_W-1:0] operand,
   input logic [7:0]        flags_in,
   input logic [DATA_W-1:0] result,
   input logic [7:0]        flags_out
);

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result) && $stable(flags_out)));

   assert_spare_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3])));

   assert_acc_keeps_szp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && acc_form) |=> (flags_out[7:6] == $past(flags_in[7:6]) &&
                               flags_out[2] == $past(flags_in[2]) &&
                               flags_out[4] == 1'b0 && flags_out[1] == 1'b0));

   assert_full_rebuild_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !acc_form) |=> (flags_out[4] == 1'b0 && flags_out[1] == 1'b0 &&
                                flags_out[6] == (result == '0) &&
                                flags_out[7] == result[DATA_W-1]));

   assert_circ_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel == 3'd0) |=> (result[0] == $past(operand[DATA_W-1]) &&
                                     flags_out[0] == $past(operand[DATA_W-1])));

   assert_thru_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel == 3'd3) |=> (result[DATA_W-1] == $past(flags_in[0]) &&
                                     flags_out[0] == $past(operand[0])));

   assert_shl_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op_sel == 3'd4 || op_sel == 3'd5)) |=>
         (flags_out[0] == $past(operand[DATA_W-1]) && result[0] == $past(op_sel[0])));

   assert_shr_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op_sel == 3'd6 || op_sel == 3'd7)) |=> (flags_out[0] == $past(operand[0])));

endmodule

bind byte_rotshift_unit byte_rotshift_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_sel    (op_sel),
   .acc_form  (acc_form),
   .operand   (operand),
   .flags_in  (flags_in),
   .result    (result),
   .flags_out (flags_out)
);

// File: tb/byte_rotshift_unit_bench.sv
module byte_rotshift_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] op_sel = '0;
   logic       acc_form = 1'b0;
   logic [7:0] operand = '0;
   logic [7:0] flags_in = '0;
   logic [7:0] result;
   logic [7:0] flags_out;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   byte_rotshift_unit u_byte_rotshift_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op_sel    (op_sel),
      .acc_form  (acc_form),
      .operand   (operand),
      .flags_in  (flags_in),
      .result    (result),
      .flags_out (flags_out)
   );

   // {op, acc, operand, flags_in, exp_result, exp_flags}
   localparam int NV = 16;
   localparam logic [35:0] VEC [NV] = '{
      {3'd0, 1'b0, 8'h81, 8'h00, 8'h03, 8'h05},  // R1 left circular
      {3'd1, 1'b0, 8'h01, 8'h00, 8'h80, 8'h81},  // R1 right circular
      {3'd2, 1'b0, 8'h80, 8'h01, 8'h01, 8'h01},  // R2 carry in set
      {3'd2, 1'b0, 8'h80, 8'h00, 8'h00, 8'h45},  // R2 carry in clear, zero result
      {3'd3, 1'b0, 8'h01, 8'h01, 8'h80, 8'h81},  // R2 right, carry in set
      {3'd3, 1'b0, 8'h02, 8'h00, 8'h01, 8'h00},  // R2 right, carry in clear
      {3'd4, 1'b0, 8'hC1, 8'h00, 8'h82, 8'h85},  // R3 zero fill
      {3'd5, 1'b0, 8'h40, 8'h00, 8'h81, 8'h84},  // R3 one fill
      {3'd6, 1'b0, 8'h81, 8'h00, 8'hC0, 8'h85},  // R4 sign kept
      {3'd7, 1'b0, 8'h81, 8'h00, 8'h40, 8'h01},  // R4 zero fill
      {3'd6, 1'b0, 8'h7E, 8'h00, 8'h3F, 8'h04},  // R4/R5 even parity
      {3'd0, 1'b1, 8'h80, 8'hFE, 8'h01, 8'hED},  // R6 keep S Z P
      {3'd3, 1'b1, 8'h01, 8'h00, 8'h00, 8'h01},  // R6 zero result, no Z
      {3'd2, 1'b1, 8'h00, 8'h13, 8'h01, 8'h00},  // R6 clear H N C
      {3'd7, 1'b0, 8'h00, 8'h28, 8'h00, 8'h6C},  // R7 spare bits, full form
      {3'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hAD}   // R5/R7 all ones
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic acc, input logic [7:0] a,
                        input logic [7:0] f);
      @(negedge clk);
      op_sel   = op;
      acc_form = acc;
      operand  = a;
      flags_in = f;
      start    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start    = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset result", result, 8'h00);
      check("R9 reset flags", flags_out, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][35:33], VEC[i][32], VEC[i][31:24], VEC[i][23:16]);
         check($sformatf("R1-4 vec %0d result", i), result, VEC[i][15:8]);
         check($sformatf("R5-7 vec %0d flags", i), flags_out, VEC[i][7:0]);
      end

      // R8: inputs move without start, outputs must hold
      apply(3'd1, 1'b0, 8'h02, 8'h00);  // result 0x01, flags 0x00
      @(negedge clk);
      op_sel   = 3'd5;
      operand  = 8'hFF;
      flags_in = 8'hFF;
      acc_form = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 hold result", result, 8'h01);
      check("R8 hold flags", flags_out, 8'h00);

      // R9: reset after activity
      apply(3'd0, 1'b0, 8'hFF, 8'hFF);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 mid-run reset result", result, 8'h00);
      check("R9 mid-run reset flags", flags_out, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule